// File: doc/BRIEF.md
# BCD Clock Calendar with Square-Wave Output

This block keeps time of day and calendar date in packed BCD. It is paced by a one-cycle clock enable at 32.768 kHz. A divider counts those enables down to one pulse per second. The pulse advances seconds, minutes, hours, day of week, date, month and a two-digit year. Hours run in either a 24-hour mode or a 12-hour mode with a PM flag. The date handles months of 30 and 31 days and February in leap years.

Software reaches the state through a byte-wide write port and a separate combinational read port, both covering addresses 0 to 7. Addresses 0 to 6 hold the time and date fields. Some control bits share those bytes: a halt flag in the seconds byte, and the 12/24 select and PM bits in the hours byte. Address 7 is a control byte that drives a square-wave output pin. The pin shows either a static level or a wave at one of four rates taken from the divider.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read: addr0 = 0x80 (halt set, 00 s), addr1 = 0x00, addr2 = 0x00 (24-hour, 00 h), addr3 = 0x01, addr4 = 0x01, addr5 = 0x01, addr6 = 0x00, addr7 = 0x03. With these values `sqw_o` is 0.
- R2: While bit 7 of addr0 is 1, the divider and all time fields hold. Writing a seconds byte with bit 7 = 1 stops a running clock.
- R3: Seconds (addr0 bits 6:0) and minutes (addr1 bits 6:0) count 00 to 59 in BCD. The step after 59 gives 00 and carries to the next field.
- R4: In 24-hour mode (addr2 bit 6 = 0) hours count 00 to 23 in BCD, using bit 5 as the tens-of-twenty bit. The step after 23 gives 00 and advances the date.
- R5: In 12-hour mode (addr2 bit 6 = 1), bit 5 is PM and bits 4:0 hold 01 to 12 in BCD. 11 steps to 12 and toggles PM. 12 steps to 01. The step from 11 PM to 12 AM advances the date.
- R6: Date (addr4) rolls from 30 to 01 in months 04, 06, 09 and 11, and from 31 to 01 in the other months except 02. Each rollover increments the month (addr5).
- R7: February ends on 29 when the year (addr6, BCD 00 to 99) is a multiple of 4 as a decimal number, and on 28 otherwise. Month 12 rolls to 01 and increments the year, and year 99 rolls to 00.
- R8: Day of week (addr3 bits 2:0) increments each time the date advances and wraps from 7 to 1.
- R9: A write to addr0 clears the sub-second divider. The next seconds step happens on exactly the 2^DIV_W-th enable after the write edge.
- R10: Control byte addr7: bit 7 is the static level, bit 4 enables the wave, and bits 1:0 select the rate. With bit 4 = 0, `sqw_o` equals bit 7. With bit 4 = 1 the rates are: rate 0 uses divider bit DIV_W-1 (1 Hz), rate 1 uses divider bit 2 (enable rate/8), rate 2 uses divider bit 1 (enable rate/4), and rate 3 uses the registered enable (enable rate).
- R11: With rate 0 enabled, the seconds field changes in the same clock edge as the falling edge of `sqw_o`, and at no other edge.
- R12: Unused bits read as 0. Reads return addr1 bits 6:0, addr3 bits 2:0, addr4 bits 5:0, addr5 bits 4:0, and addr7 bits 7, 4, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Write address |
| wdata_i | input | 8 | Write data |
| raddr_i | input | 3 | Read address |
| rdata_o | output | 8 | Read data (combinational) |
| sqw_o | output | 1 | Square-wave or static level output |

## Verification
Four corner cases are targeted, along with the failure each one would expose.

- **12-hour crossings.** The bench drives the 11 to 12 step in the morning and at night, and the 12 to 1 step. A design that toggled PM on the wrong step would show it, as would one that advanced the date at noon instead of midnight.
- **Month ends.** The bench runs each short month and February, including year 10. That year is a multiple of 4 in raw BCD bits but not in decimal, so it catches a leap test done on the raw bits.
- **Divider clear.** The bench counts the exact number of enables to the next second after a seconds write. An off-by-one or missing clear shows up as a step one enable early or late.
- **Square-wave edges.** Toggle counts and duty at each rate catch a swapped tap. The bench also checks that, at 1 Hz, the seconds step lands on the falling edge of the wave and not one cycle off.

// File: rtl/bcd_rtc_pkg.sv
`timescale 1ns/100ps
package bcd_rtc_pkg;

  localparam logic [2:0] ADDR_SEC  = 3'd0;
  localparam logic [2:0] ADDR_MIN  = 3'd1;
  localparam logic [2:0] ADDR_HR   = 3'd2;
  localparam logic [2:0] ADDR_DOW  = 3'd3;
  localparam logic [2:0] ADDR_DATE = 3'd4;
  localparam logic [2:0] ADDR_MON  = 3'd5;
  localparam logic [2:0] ADDR_YR   = 3'd6;
  localparam logic [2:0] ADDR_CTRL = 3'd7;

  typedef struct packed {
    logic       lvl;
    logic       wave_en;
    logic [1:0] rate;
  } sqw_ctrl_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // decimal value of the BCD year, multiple of 4
  function automatic logic is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [5:0] month_end(input logic [4:0] mon, input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/100ps
module rtc_prescaler #(
  parameter int unsigned DIV_W = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic clear_i,
  output logic sec_pulse_o,
  output logic tap_1hz_o,
  output logic tap_div8_o,
  output logic tap_div4_o,
  output logic tick_q_o
);

  localparam logic [DIV_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] cnt_q;
  logic             step;

  assign step = tick_i & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      tick_q_o <= 1'b0;
    end else begin
      tick_q_o <= step;
      if (clear_i)   cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  // wrap of the divider is the seconds step; MSB falls on the same edge
  assign sec_pulse_o = step & ~clear_i & (cnt_q == CNT_MAX);
  assign tap_1hz_o   = cnt_q[DIV_W-1];
  assign tap_div8_o  = cnt_q[2];
  assign tap_div4_o  = cnt_q[1];

endmodule

// File: rtl/rtc_sqw_gen.sv
`timescale 1ns/100ps
module rtc_sqw_gen
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  sqw_ctrl_t ctrl_i,
  input  logic      tap_1hz_i,
  input  logic      tap_div8_i,
  input  logic      tap_div4_i,
  input  logic      tick_q_i,
  output logic      sqw_o
);

  localparam int unsigned N_RATES = 4;

  if (DIV_W < 4) begin : g_bad_div
    $error("rtc_sqw_gen: DIV_W must be at least 4");
  end

  logic [N_RATES-1:0] taps;
  assign taps  = {tick_q_i, tap_div4_i, tap_div8_i, tap_1hz_i};
  assign sqw_o = ctrl_i.wave_en ? taps[ctrl_i.rate] : ctrl_i.lvl;

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/100ps
module rtc_calendar
  import bcd_rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_pulse_i,
  input  logic       wr_en_i,
  input  logic [2:0] waddr_i,
  input  logic [7:0] wdata_i,
  output logic       halt_o,
  output logic [6:0] sec_o,
  output logic [6:0] min_o,
  output logic [6:0] hr_o,
  output logic [2:0] dow_o,
  output logic [5:0] date_o,
  output logic [4:0] mon_o,
  output logic [7:0] yr_o
);

  logic       halt_q;
  logic [6:0] sec_q, min_q, hr_q;
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;
  logic [7:0] yr_q;

  logic [6:0] sec_n, min_n, hr_n;
  logic [2:0] dow_n;
  logic [5:0] date_n;
  logic [4:0] mon_n;
  logic [7:0] yr_n;
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_yr;

  always_comb begin
    sec_n  = sec_q;  min_n = min_q; hr_n = hr_q; dow_n = dow_q;
    date_n = date_q; mon_n = mon_q; yr_n = yr_q;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0; c_mon = 1'b0; c_yr = 1'b0;
    t_sec  = bcd_inc({1'b0, sec_q});
    t_min  = bcd_inc({1'b0, min_q});
    t_hr   = hr_q[6] ? bcd_inc({3'b0, hr_q[4:0]}) : bcd_inc({2'b0, hr_q[5:0]});
    t_date = bcd_inc({2'b0, date_q});
    t_mon  = bcd_inc({3'b0, mon_q});
    t_yr   = bcd_inc(yr_q);

    if (sec_pulse_i) begin
      if (sec_q == 7'h59) begin sec_n = 7'h00; c_min = 1'b1; end
      else                      sec_n = t_sec[6:0];
    end

    if (c_min) begin
      if (min_q == 7'h59) begin min_n = 7'h00; c_hr = 1'b1; end
      else                      min_n = t_min[6:0];
    end

    if (c_hr) begin
      if (hr_q[6]) begin
        if (hr_q[4:0] == 5'h12) begin
          hr_n = {1'b1, hr_q[5], 5'h01};
        end else if (hr_q[4:0] == 5'h11) begin
          hr_n  = {1'b1, ~hr_q[5], 5'h12};
          c_day = hr_q[5];            // 11 PM -> 12 AM is midnight
        end else begin
          hr_n = {1'b1, hr_q[5], t_hr[4:0]};
        end
      end else begin
        if (hr_q[5:0] == 6'h23) begin hr_n = 7'h00; c_day = 1'b1; end
        else                          hr_n = {1'b0, t_hr[5:0]};
      end
    end

    if (c_day) begin
      dow_n = (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (date_q == month_end(mon_q, yr_q)) begin date_n = 6'h01; c_mon = 1'b1; end
      else                                         date_n = t_date[5:0];
    end

    if (c_mon) begin
      if (mon_q == 5'h12) begin mon_n = 5'h01; c_yr = 1'b1; end
      else                      mon_n = t_mon[4:0];
    end

    if (c_yr) yr_n = (yr_q == 8'h99) ? 8'h00 : t_yr;
  end

  // write to a field overrides the advance of that field in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b1;
      sec_q  <= 7'h00; min_q <= 7'h00; hr_q <= 7'h00;
      dow_q  <= 3'd1;  date_q <= 6'h01; mon_q <= 5'h01; yr_q <= 8'h00;
    end else begin
      sec_q  <= sec_n;  min_q <= min_n; hr_q <= hr_n; dow_q <= dow_n;
      date_q <= date_n; mon_q <= mon_n; yr_q <= yr_n;
      if (wr_en_i) begin
        case (waddr_i)
          ADDR_SEC:  begin halt_q <= wdata_i[7]; sec_q <= wdata_i[6:0]; end
          ADDR_MIN:  min_q  <= wdata_i[6:0];
          ADDR_HR:   hr_q   <= wdata_i[6:0];
          ADDR_DOW:  dow_q  <= wdata_i[2:0];
          ADDR_DATE: date_q <= wdata_i[5:0];
          ADDR_MON:  mon_q  <= wdata_i[4:0];
          ADDR_YR:   yr_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign halt_o = halt_q;
  assign sec_o  = sec_q;  assign min_o  = min_q; assign hr_o  = hr_q;
  assign dow_o  = dow_q;  assign date_o = date_q;
  assign mon_o  = mon_q;  assign yr_o   = yr_q;

endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/100ps
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] waddr_i,
  input  logic [7:0] wdata_i,
  input  logic [2:0] raddr_i,
  output logic [7:0] rdata_o,
  output logic       sqw_o
);

  logic       halt;
  logic [6:0] sec, min, hr;
  logic [2:0] dow;
  logic [5:0] date;
  logic [4:0] mon;
  logic [7:0] yr;
  logic       sec_pulse, sec_wr;
  logic       tap_1hz, tap_div8, tap_div4, tick_q;
  sqw_ctrl_t  ctrl_q;

  assign sec_wr = wr_en_i && (waddr_i == ADDR_SEC);

  rtc_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .run_i      (~halt),
    .clear_i    (sec_wr),
    .sec_pulse_o(sec_pulse),
    .tap_1hz_o  (tap_1hz),
    .tap_div8_o (tap_div8),
    .tap_div4_o (tap_div4),
    .tick_q_o   (tick_q)
  );

  rtc_calendar u_cal (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_pulse_i(sec_pulse),
    .wr_en_i    (wr_en_i),
    .waddr_i    (waddr_i),
    .wdata_i    (wdata_i),
    .halt_o     (halt),
    .sec_o      (sec),
    .min_o      (min),
    .hr_o       (hr),
    .dow_o      (dow),
    .date_o     (date),
    .mon_o      (mon),
    .yr_o       (yr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{lvl: 1'b0, wave_en: 1'b0, rate: 2'b11};
    end else if (wr_en_i && (waddr_i == ADDR_CTRL)) begin
      ctrl_q.lvl     <= wdata_i[7];
      ctrl_q.wave_en <= wdata_i[4];
      ctrl_q.rate    <= wdata_i[1:0];
    end
  end

  rtc_sqw_gen #(.DIV_W(DIV_W)) u_sqw (
    .ctrl_i    (ctrl_q),
    .tap_1hz_i (tap_1hz),
    .tap_div8_i(tap_div8),
    .tap_div4_i(tap_div4),
    .tick_q_i  (tick_q),
    .sqw_o     (sqw_o)
  );

  always_comb begin
    case (raddr_i)
      ADDR_SEC:  rdata_o = {halt, sec};
      ADDR_MIN:  rdata_o = {1'b0, min};
      ADDR_HR:   rdata_o = {1'b0, hr};
      ADDR_DOW:  rdata_o = {5'b0, dow};
      ADDR_DATE: rdata_o = {2'b0, date};
      ADDR_MON:  rdata_o = {3'b0, mon};
      ADDR_YR:   rdata_o = yr;
      default:   rdata_o = {ctrl_q.lvl, 2'b0, ctrl_q.wave_en, 2'b0, ctrl_q.rate};
    endcase
  end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
`timescale 1ns/100ps
module bcd_rtc_core_chk #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       waddr_i,
  input logic             sqw_o,
  input logic             sec_pulse,
  input logic [DIV_W-1:0] cnt,
  input logic             halt,
  input logic [6:0]       sec,
  input logic [2:0]       dow,
  input logic             ctrl_lvl,
  input logic             ctrl_wave_en
);

  a_r2_halt_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |-> !sec_pulse);

  a_r2_halt_sec_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !wr_en_i) |=> $stable(sec));

  a_r3_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse && sec == 7'h59 && !(wr_en_i && waddr_i == 3'd0)) |=> (sec == 7'h00));

  a_r8_dow_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dow == 3'd7 && !(wr_en_i && waddr_i == 3'd3)) |=> (dow == 3'd7 || dow == 3'd1));

  a_r9_sec_write_clears_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && waddr_i == 3'd0) |=> (cnt == '0));

  a_r11_pulse_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse |=> (cnt == '0));

  a_r10_static_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wave_en |-> (sqw_o == ctrl_lvl));

endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .waddr_i     (waddr_i),
  .sqw_o       (sqw_o),
  .sec_pulse   (sec_pulse),
  .cnt         (u_pre.cnt_q),
  .halt        (halt),
  .sec         (sec),
  .dow         (dow),
  .ctrl_lvl    (ctrl_q.lvl),
  .ctrl_wave_en(ctrl_q.wave_en)
);

// File: tb/bcd_rtc_core_tb.sv
`timescale 1ns/100ps
module bcd_rtc_core_tb;

  localparam int unsigned DIV_W = 4;
  localparam int unsigned TPS   = 1 << DIV_W;

  logic       clk, rst_n, tick, wr_en;
  logic [2:0] waddr, raddr;
  logic [7:0] wdata, rdata;
  logic       sqw;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bcd_rtc_core #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .waddr_i(waddr), .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata), .sqw_o(sqw)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [2:0] a;
    logic [7:0] e;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // monitor: pops expected reads and compares against the read port
  initial begin
    raddr = 3'd0;
    forever begin
      @(negedge clk);
      #0.5;
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        raddr = it.a;
        #0.1;
        chk(it.tag, rdata, it.e);
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    sb_q.push_back('{a: a, e: e, tag: tag});
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(3'd0, 8'h80 | s);
    wr(3'd1, m); wr(3'd2, h); wr(3'd3, dw);
    wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, y);
    wr(3'd0, s);
  endtask

  task automatic adv_secs(input int n);
    repeat (n * TPS) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_date(input logic [7:0] dt, mo, y, input string tag);
    expect_reg(3'd4, dt, tag);
    expect_reg(3'd5, mo, tag);
    expect_reg(3'd6, y, tag);
    drain();
  endtask

  task automatic sample_wave(output int ones, output int toggles);
    logic prev;
    ones = 0; toggles = 0;
    @(negedge clk);
    prev = sqw;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ones += int'(sqw);
      if (sqw != prev) toggles++;
      prev = sqw;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ones, togg, mism, falls;
    logic       pw;
    logic [7:0] ps;
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; waddr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick  = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_reg(3'd0, 8'h80, "R1 sec");
    expect_reg(3'd1, 8'h00, "R1 min");
    expect_reg(3'd2, 8'h00, "R1 hr");
    expect_reg(3'd3, 8'h01, "R1 dow");
    expect_reg(3'd4, 8'h01, "R1 date");
    expect_reg(3'd5, 8'h01, "R1 mon");
    expect_reg(3'd6, 8'h00, "R1 yr");
    expect_reg(3'd7, 8'h03, "R1 ctrl");
    drain();
    chk("R1 sqw", {7'd0, sqw}, 8'h00);

    // R2 halted after reset: nothing moves
    repeat (3 * TPS) @(negedge clk);
    expect_reg(3'd0, 8'h80, "R2 halted sec");
    drain();

    // R9 seconds write clears divider, step at exactly TPS enables
    wr(3'd0, 8'h05);
    repeat (TPS - 1) @(posedge clk);
    @(negedge clk);
    expect_reg(3'd0, 8'h05, "R9 before step");
    drain();
    @(posedge clk); @(negedge clk);
    expect_reg(3'd0, 8'h06, "R9 at step");
    drain();

    // R2 halt a running clock
    wr(3'd0, 8'hB0);
    adv_secs(2);
    expect_reg(3'd0, 8'hB0, "R2 halt running");
    drain();

    // R3 seconds/minutes carry
    set_time(8'h58, 8'h59, 8'h00, 8'h02, 8'h01, 8'h01, 8'h00);
    adv_secs(2);
    expect_reg(3'd0, 8'h00, "R3 sec");
    expect_reg(3'd1, 8'h00, "R3 min");
    expect_reg(3'd2, 8'h01, "R3 hr");
    expect_reg(3'd3, 8'h02, "R3 dow kept");
    drain();

    // R4 / R8 midnight in 24-hour mode, dow 7 -> 1
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h21);
    adv_secs(1);
    expect_reg(3'd2, 8'h00, "R4 hr 23->00");
    expect_reg(3'd3, 8'h01, "R8 dow 7->1");
    expect_reg(3'd4, 8'h16, "R4 date");
    drain();

    // R5 12-hour mode
    set_time(8'h59, 8'h59, 8'h51, 8'h01, 8'h10, 8'h06, 8'h22);
    adv_secs(1);
    expect_reg(3'd2, 8'h72, "R5 11AM->12PM");
    expect_reg(3'd4, 8'h10, "R5 noon no date");
    drain();
    set_time(8'h59, 8'h59, 8'h72, 8'h01, 8'h10, 8'h06, 8'h22);
    adv_secs(1);
    expect_reg(3'd2, 8'h61, "R5 12PM->1PM");
    drain();
    set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h10, 8'h06, 8'h22);
    adv_secs(1);
    expect_reg(3'd2, 8'h52, "R5 11PM->12AM");
    expect_reg(3'd3, 8'h04, "R8 dow step");
    expect_reg(3'd4, 8'h11, "R5 midnight date");
    drain();

    // R6 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h22);
    adv_secs(1);
    expect_date(8'h01, 8'h05, 8'h22, "R6 30 Apr");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h09, 8'h22);
    adv_secs(1);
    expect_date(8'h01, 8'h10, 8'h22, "R6 30 Sep");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h22);
    adv_secs(1);
    expect_date(8'h31, 8'h05, 8'h22, "R6 30 May");

    // R7 February and year end
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    adv_secs(1);
    expect_date(8'h29, 8'h02, 8'h24, "R7 leap 24");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    adv_secs(1);
    expect_date(8'h01, 8'h03, 8'h24, "R7 29 Feb end");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    adv_secs(1);
    expect_date(8'h01, 8'h03, 8'h23, "R7 non-leap 23");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10);
    adv_secs(1);
    expect_date(8'h01, 8'h03, 8'h10, "R7 non-leap 10");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    adv_secs(1);
    expect_date(8'h29, 8'h02, 8'h00, "R7 leap 00");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    adv_secs(1);
    expect_date(8'h01, 8'h01, 8'h00, "R7 year wrap");

    // R10 static level and rates
    wr(3'd7, 8'h80);
    chk("R10 static high", {7'd0, sqw}, 8'h01);
    wr(3'd7, 8'h00);
    chk("R10 static low", {7'd0, sqw}, 8'h00);
    wr(3'd7, 8'h11);
    sample_wave(ones, togg);
    chk("R10 rate1 duty", 8'(ones), 8'd8);
    chk("R10 rate1 toggles", {7'd0, (togg == 3 || togg == 4)}, 8'h01);
    wr(3'd7, 8'h12);
    sample_wave(ones, togg);
    chk("R10 rate2 duty", 8'(ones), 8'd8);
    chk("R10 rate2 toggles", {7'd0, (togg == 7 || togg == 8)}, 8'h01);
    wr(3'd7, 8'h10);
    sample_wave(ones, togg);
    chk("R10 rate0 duty", 8'(ones), 8'd8);
    chk("R10 rate0 toggles", {7'd0, (togg == 1 || togg == 2)}, 8'h01);
    wr(3'd7, 8'h13);
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ones += int'(sqw);
      tick = i[0];
    end
    tick = 1'b1;
    chk("R10 rate3 follows enable", 8'(ones), 8'd8);

    // R11 seconds step on the falling edge of the 1 Hz wave
    wr(3'd7, 8'h10);
    raddr = 3'd0;
    #0.5;
    pw = sqw; ps = rdata;
    mism = 0; falls = 0;
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk);
      #0.5;
      if ((pw && !sqw) != (rdata != ps)) mism++;
      if (pw && !sqw) falls++;
      pw = sqw; ps = rdata;
    end
    chk("R11 step vs fall mismatches", 8'(mism), 8'd0);
    chk("R11 falls seen", {7'd0, (falls >= 2)}, 8'h01);

    // R12 unused bits read zero
    wr(3'd1, 8'hFF);
    wr(3'd3, 8'hFF);
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'hFF);
    expect_reg(3'd1, 8'h7F, "R12 min mask");
    expect_reg(3'd3, 8'h07, "R12 dow mask");
    expect_reg(3'd4, 8'h3F, "R12 date mask");
    expect_reg(3'd5, 8'h1F, "R12 mon mask");
    expect_reg(3'd7, 8'h93, "R12 ctrl mask");
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule